// File: doc/BRIEF.md
# Hardware Lock Bank for Multi-Processor Coordination

This block holds a set of single-bit hardware locks that several processors on a shared register bus use to guard common resources. Each lock sits behind its own 32-bit word register. A plain read of that register is the acquire attempt. If the lock was free, the read returns 0, and in the same clock edge the lock becomes taken, so that reader now owns it. If the lock was already taken, the read returns 1 and nothing changes. The owner gives the lock back by writing 0 to the same register.

The bus arbiter upstream presents one access per cycle. Two reads of one free lock therefore always land in different cycles, and only the first of them sees 0. Two more registers sit beside the lock words. A read-only occupancy register shows every lock state in one word. A read-only identity register reports how many locks the bank holds. Read data comes back one cycle after the request.

Top module: `hwlock_bank`

## Requirements
- R1: After reset every lock is free, the occupancy register reads 0, and `rsp_valid` and `rsp_rdata` are 0.
- R2: Lock i (0 to 31) is addressed at byte offset 0x100 + 4*i. Only word-aligned offsets in 0x100..0x17C select a lock.
- R3: A read of a free lock returns 0 and the lock is taken from the next cycle on.
- R4: A read of a taken lock returns 1 (data bit 0 set, all other bits 0) and leaves the lock taken.
- R5: A write of 0x00000000 to a lock register frees that lock from the next cycle on.
- R6: A write of any nonzero value to a lock register leaves that lock unchanged.
- R7: The occupancy register at offset 0x10 reads back a word whose bit i is the state of lock i before that cycle's edge (1 = taken). Reading it changes no lock, and writes to it are ignored.
- R8: The identity register at offset 0x0 reads 32 (0x00000020) and ignores writes.
- R9: Any other offset, including misaligned offsets inside the lock range, reads 0 and ignores writes.
- R10: Two reads of the same free lock in back-to-back cycles return 0 and then 1.
- R11: `rsp_valid` is 1 exactly in the cycle after a read request, and `rsp_rdata` is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read (acquire attempt for lock words) |
| req_addr | input | 12 | Byte offset within the 4 KiB register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data is present this cycle |
| rsp_rdata | output | 32 | Read data for the request of the previous cycle |

## Verification
The bench aims at the race the block exists for: back-to-back reads of one free lock. A design that updated the lock too late would hand 0 to both readers and grant ownership twice. It releases with nonzero data and writes to the occupancy and identity registers. A design that decoded writes loosely would free a lock that is still owned, or make a lock look taken when it is not. It probes misaligned and just-out-of-range offsets, where a sloppy index calculation would alias onto a real lock and acquire it silently. A long mixed stream of acquires, releases and occupancy reads is then checked cycle by cycle against a behavioural model, to catch any slip in when a state change becomes visible.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

   typedef enum logic [1:0] {
      RGN_NONE   = 2'd0,
      RGN_IDENT  = 2'd1,
      RGN_OCCUPY = 2'd2,
      RGN_LOCK   = 2'd3
   } hwl_region_e;

   function automatic int hwl_idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
   import hwlock_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int NUM_LOCKS  = 32,
   parameter int LOCK_BASE  = 'h100,
   parameter int IDENT_OFS  = 'h0,
   parameter int OCCUPY_OFS = 'h10,
   localparam int IDX_W     = hwl_idx_width(NUM_LOCKS)
) (
   input  logic [ADDR_W-1:0] addr,
   output hwl_region_e       region,
   output logic [IDX_W-1:0]  idx
);
   localparam int LOCK_END = LOCK_BASE + 4 * NUM_LOCKS;

   logic [ADDR_W-1:0] off;
   logic              in_range;
   logic              aligned;

   always_comb begin
      off      = addr - ADDR_W'(LOCK_BASE);
      aligned  = (addr[1:0] == 2'b00);
      in_range = (addr >= ADDR_W'(LOCK_BASE)) && ({1'b0, addr} < (ADDR_W+1)'(LOCK_END));
      region   = RGN_NONE;
      idx      = '0;
      if (addr == ADDR_W'(IDENT_OFS)) begin
         region = RGN_IDENT;
      end else if (addr == ADDR_W'(OCCUPY_OFS)) begin
         region = RGN_OCCUPY;
      end else if (aligned && in_range) begin
         region = RGN_LOCK;
         idx    = IDX_W'(off >> 2);
      end
   end

endmodule

// File: rtl/hwlock_cell.sv
module hwlock_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic grab,
   input  logic drop,
   input  logic poke,
   output logic held
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held <= 1'b0;
      else if (grab) held <= 1'b1;
      else if (drop) held <= 1'b0;
   end

   p_grab_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grab |=> held);
   p_taken_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !drop) |=> held);
   p_drop_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> !held);
   p_poke_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (poke && !grab) |=> (held == $past(held)));

endmodule

// File: rtl/hwlock_rdmux.sv
module hwlock_rdmux
   import hwlock_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_LOCKS = 32,
   localparam int IDX_W    = hwl_idx_width(NUM_LOCKS)
) (
   input  hwl_region_e          region,
   input  logic [IDX_W-1:0]     idx,
   input  logic [NUM_LOCKS-1:0] lock_vec,
   output logic [DATA_W-1:0]    rdata
);
   logic sel_bit;

   always_comb begin
      sel_bit = 1'b0;
      for (int k = 0; k < NUM_LOCKS; k++) begin
         if (idx == IDX_W'(k)) sel_bit = lock_vec[k];
      end
      unique case (region)
         RGN_IDENT:  rdata = DATA_W'(NUM_LOCKS);
         RGN_OCCUPY: rdata = DATA_W'(lock_vec);
         RGN_LOCK:   rdata = DATA_W'(sel_bit);
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
   import hwlock_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int NUM_LOCKS  = 32,
   parameter int LOCK_BASE  = 'h100,
   parameter int IDENT_OFS  = 'h0,
   parameter int OCCUPY_OFS = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int IDX_W = hwl_idx_width(NUM_LOCKS);

   if (NUM_LOCKS < 1 || NUM_LOCKS > DATA_W) begin : g_bad_count
      $error("hwlock_bank: NUM_LOCKS must lie in 1..DATA_W");
   end
   if (LOCK_BASE + 4 * NUM_LOCKS > (1 << ADDR_W)) begin : g_bad_window
      $error("hwlock_bank: lock words do not fit the address window");
   end
   if ((LOCK_BASE % 4) != 0) begin : g_bad_base
      $error("hwlock_bank: LOCK_BASE must be word aligned");
   end

   hwl_region_e          region;
   logic [IDX_W-1:0]     idx;
   logic [NUM_LOCKS-1:0] lock_vec;
   logic [DATA_W-1:0]    rd_next;
   logic                 is_rd;
   logic                 is_wr;
   logic                 wr_zero;

   assign is_rd   = req_valid && !req_write;
   assign is_wr   = req_valid &&  req_write;
   assign wr_zero = (req_wdata == '0);

   hwlock_decode #(
      .ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS), .LOCK_BASE(LOCK_BASE),
      .IDENT_OFS(IDENT_OFS), .OCCUPY_OFS(OCCUPY_OFS)
   ) decode_i (
      .addr(req_addr), .region(region), .idx(idx)
   );

   for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
      logic hit;
      assign hit = (region == RGN_LOCK) && (idx == IDX_W'(g));
      hwlock_cell cell_i (
         .clk  (clk),
         .rst_n(rst_n),
         .grab (is_rd && hit),
         .drop (is_wr && hit && wr_zero),
         .poke (is_wr && hit && !wr_zero),
         .held (lock_vec[g])
      );
   end

   hwlock_rdmux #(.DATA_W(DATA_W), .NUM_LOCKS(NUM_LOCKS)) rdmux_i (
      .region(region), .idx(idx), .lock_vec(lock_vec), .rdata(rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= is_rd;
         rsp_rdata <= is_rd ? rd_next : '0;
      end
   end

   // R3, R10: winning read sees 0 and leaves the lock taken
   p_free_read_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && region == RGN_LOCK && !lock_vec[idx])
      |=> (rsp_rdata == '0 && lock_vec[$past(idx)]));
   // R4: losing read sees 1
   p_taken_read_loses_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && region == RGN_LOCK && lock_vec[idx])
      |=> (rsp_rdata == DATA_W'(1)));
   // R7: occupancy read mirrors the vector and changes nothing
   p_occupy_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && region == RGN_OCCUPY)
      |=> (rsp_rdata == DATA_W'($past(lock_vec)) && $stable(lock_vec)));
   // R8: identity register value
   p_ident_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && region == RGN_IDENT) |=> (rsp_rdata == DATA_W'(NUM_LOCKS)));
   // R9: unmapped offsets are inert
   p_unmapped_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && region == RGN_NONE) |=> ($stable(lock_vec) && rsp_rdata == '0));
   // R11: response timing
   p_rsp_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> rsp_valid);
   p_rsp_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> (!rsp_valid && rsp_rdata == '0));

endmodule

// File: tb/hwlock_bank_tb.sv
module hwlock_bank_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   hwlock_bank dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   int          checks = 0;
   int          bad = 0;
   bit          finished = 0;
   bit [31:0]   model_locks = '0;
   bit          pend = 0;
   bit          exp_v;
   bit [31:0]   exp_d;
   string       ptag;

   task automatic check_now(input string tag, input bit ev, input bit [31:0] ed);
      checks++;
      if (rsp_valid !== ev || rsp_rdata !== ed) begin
         bad++;
         $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                  tag, rsp_valid, rsp_rdata, ev, ed);
      end
   endtask

   // offset classification written from the requirements (R2, R8, R9)
   function automatic int lock_of(input bit [11:0] a);
      if (a[1:0] == 2'b00 && a >= 12'h100 && a <= 12'h17C) return int'((a - 12'h100) / 4);
      return -1;
   endfunction

   task automatic op(input bit v, input bit w, input bit [11:0] a,
                     input bit [31:0] d, input string tag);
      int li;
      @(negedge clk);
      if (pend) check_now(ptag, exp_v, exp_d);
      req_valid = v; req_write = w; req_addr = a; req_wdata = d;
      li = lock_of(a);
      exp_v = v && !w;
      exp_d = '0;
      if (v && !w) begin
         if (a == 12'h000)      exp_d = 32'd32;
         else if (a == 12'h010) exp_d = model_locks;
         else if (li >= 0) begin
            exp_d = {31'b0, model_locks[li]};
            model_locks[li] = 1'b1;
         end
      end else if (v && w && li >= 0 && d == 32'h0) begin
         model_locks[li] = 1'b0;
      end
      pend = 1; ptag = tag;
   endtask

   task automatic rd(input bit [11:0] a, input string tag); op(1, 0, a, '0, tag); endtask
   task automatic wr(input bit [11:0] a, input bit [31:0] d, input string tag); op(1, 1, a, d, tag); endtask
   task automatic idle(input string tag); op(0, 0, '0, '0, tag); endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!finished) begin
         bad++; checks++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin : stim
      bit [31:0] lfsr = 32'hACE1_1234;
      repeat (3) @(negedge clk);
      check_now("R1 reset outputs", 1'b0, 32'h0);
      rst_n = 1'b1;
      idle("R1 idle after reset");
      rd(12'h010, "R1 occupancy clear after reset");
      rd(12'h000, "R8 identity value");
      wr(12'h000, 32'h0, "R8 identity write");
      rd(12'h000, "R8 identity unchanged after write");
      // R3 / R4 / R10: back-to-back acquire race on lock 0
      rd(12'h100, "R3 acquire free lock 0");
      rd(12'h100, "R10 second back-to-back read loses");
      rd(12'h100, "R4 taken read returns 1");
      rd(12'h010, "R7 occupancy after lock 0");
      // R2: acquire every lock by its own offset
      for (int i = 0; i < 32; i++) rd(12'(12'h100 + 4*i), "R2 acquire by offset");
      rd(12'h010, "R7 occupancy all taken");
      wr(12'h010, 32'h0, "R7 occupancy write");
      rd(12'h010, "R7 occupancy unchanged by write");
      // R6 / R5
      wr(12'h114, 32'h1, "R6 nonzero write");
      rd(12'h114, "R6 lock 5 still taken");
      wr(12'h114, 32'hFFFF_FFFF, "R6 all-ones write");
      rd(12'h114, "R6 lock 5 still taken again");
      wr(12'h114, 32'h0, "R5 release lock 5");
      rd(12'h010, "R5 occupancy shows lock 5 free");
      rd(12'h114, "R3 reacquire lock 5");
      // R9: unmapped and misaligned
      wr(12'h11C, 32'h0, "R5 release lock 7");
      wr(12'h11D, 32'h0, "R9 misaligned write");
      wr(12'h11E, 32'h0, "R9 misaligned write");
      rd(12'h11D, "R9 misaligned read");
      rd(12'h180, "R9 just past range");
      rd(12'h0FC, "R9 just below range");
      rd(12'hFFC, "R9 top of window");
      rd(12'h010, "R9 lock 7 still free only");
      rd(12'h11C, "R3 acquire lock 7");
      // release everything
      for (int i = 0; i < 32; i++) wr(12'(12'h100 + 4*i), 32'h0, "R5 release all");
      rd(12'h010, "R5 occupancy clear");
      // mixed stream
      for (int n = 0; n < 1500; n++) begin
         bit [11:0] a;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = (lfsr[9:7] == 3'd0) ? 12'h010 : 12'(12'h100 + {lfsr[4:0], 2'b00});
         if (lfsr[12:10] == 3'd0) idle("R11 stream idle");
         else if (lfsr[5]) op(1, 1, a, lfsr[6] ? 32'h0 : lfsr, "R11 stream write");
         else rd(a, "R11 stream read");
      end
      idle("R11 final flush");
      idle("R11 final quiet");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule